// File: doc/BRIEF.md
# Translation Unit Control and Fault Register Block

This block is the software-visible register file and the control state machine of an address translation unit. Software talks to it through a 32-bit register port with a write strobe, a 12-bit byte address and a combinational read path. The block holds the table base, a configuration word and two prefetch address windows, and passes them on to the translation path. It tells the translation path whether translation is on and whether it must hold back new requests.

The control state machine has four states. S_OFF means translation is disabled. S_RUN means translation is enabled. S_HOLD_REQ means a hold has been asked for and the datapath has not yet drained. S_HELD means translation is stopped. The transitions are as follows. A control write of 0x5 goes to S_RUN from any state. A control write of 0x0 goes to S_OFF from any state. A control write of 0x7 goes from S_OFF or S_RUN to S_HOLD_REQ. S_HOLD_REQ goes to S_HELD when the datapath reports idle. Any accepted fault goes to S_HELD from S_RUN, S_HOLD_REQ or S_HELD, and the fault takes priority over a control write in the same cycle.

The datapath reports faults as a valid strobe with a 3-bit type and the faulting address. The block sets the interrupt status bit that belongs to the type and raises an interrupt. It stores the address in one of four capture registers chosen by the type. Writes to the two flush registers produce one-cycle invalidate pulses for the translation cache.

Top module: `xlt_ctrl_top`

## Requirements
- R1: After reset, control (0x000), status (0x008) and interrupt status (0x018) read 0 and `irq` is low. Each prefetch window reads start 0x00000000 and end 0xFFFFFFFF.
- R2: A control write of 0x5, 0x0 or 0x7 selects S_RUN, S_OFF or S_HOLD_REQ as described above. Any other control value leaves the state unchanged. Control reads back 0x5 in S_RUN, 0x7 in S_HOLD_REQ and S_HELD, and 0x0 in S_OFF. `xlt_on` is high outside S_OFF. `xlt_hold` is high in S_HOLD_REQ and S_HELD.
- R3: S_HOLD_REQ becomes S_HELD only on an edge where `dp_idle` is high, and never earlier than the edge after the 0x7 write. Status bit 0 is 1 exactly in S_HELD.
- R4: A fault accepted outside S_OFF does three things on the next edge: it sets interrupt status bit `flt_type`, it raises `irq`, and it enters S_HELD. This also happens when a control write arrives in the same cycle. A fault reported in S_OFF changes nothing.
- R5: The interrupt status bits are: 0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write access. The faulting address is captured as follows: type 0 into 0x024; types 2, 6 and 7 into 0x028; types 1, 4 and 5 into 0x02C; type 3 into 0x030.
- R6: If a fault arrives while its type's status bit is already set, the status bit stays set and the captured address is not overwritten.
- R7: Writing the interrupt clear register (0x01C) clears every status bit written as 1 and leaves bits written as 0 alone. A fault in the same cycle sets its bit anyway. `irq` is the OR of all status bits.
- R8: Writing 0x00C with bit 0 set gives a `flush_all` pulse of exactly one cycle after the write edge. Writing it with bit 0 clear gives no pulse.
- R9: Writing 0x010 with bit 0 set gives a one-cycle `flush_entry` pulse, and `flush_page` carries write bits [31:12]. Writing it with bit 0 clear gives no pulse.
- R10: The configuration word (0x004) and the table base (0x014) are read/write and appear on `cfg_word` and `tbl_base`.
- R11: Prefetch window 0 uses start 0x04C and inclusive end 0x050. Window 1 uses 0x054 and 0x058. Window w sits at bits [32w+31:32w] of `pf_start` and `pf_end`.
- R12: The version register (0x034) is read-only and has major version 3 in bits [31:28]. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| dp_idle | input | 1 | Datapath has no request in flight |
| flt_valid | input | 1 | Fault report strobe |
| flt_type | input | 3 | Fault type (status bit index) |
| flt_addr | input | 32 | Faulting address |
| xlt_on | output | 1 | Translation enabled |
| xlt_hold | output | 1 | Translation must hold new requests |
| irq | output | 1 | Fault interrupt |
| flush_all | output | 1 | One-cycle invalidate-all pulse |
| flush_entry | output | 1 | One-cycle single-page invalidate pulse |
| flush_page | output | 20 | Page number for flush_entry |
| cfg_word | output | 32 | Configuration word |
| tbl_base | output | 32 | Translation table base |
| pf_start | output | 64 | Prefetch window start addresses |
| pf_end | output | 64 | Prefetch window inclusive end addresses |

## Verification
Every state, status, capture and configuration register changes on the edge that samples the write or fault. Because reads are combinational, the bench reads the result one nanosecond after that edge. The flush pulses are registered, so they are visible in the one cycle after the write edge and are checked low again one edge later. The hold handshake needs at least two edges: one to enter S_HOLD_REQ and one on which `dp_idle` is high. The bench checks status after each edge while `dp_idle` is held low, and again after the edge where it rises. A bench model steps once for each clock edge using the inputs driven for that edge, and all outputs are compared after that edge.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int REG_AW     = 12;
    localparam int DW         = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PAGE_W     = DW - PAGE_SHIFT;
    localparam int NUM_FTYPES = 8;
    localparam int FT_W       = $clog2(NUM_FTYPES);
    localparam int NUM_FREGS  = 4;

    localparam logic [REG_AW-1:0] A_CTRL    = 12'h000;
    localparam logic [REG_AW-1:0] A_CFG     = 12'h004;
    localparam logic [REG_AW-1:0] A_STAT    = 12'h008;
    localparam logic [REG_AW-1:0] A_FLALL   = 12'h00C;
    localparam logic [REG_AW-1:0] A_FLONE   = 12'h010;
    localparam logic [REG_AW-1:0] A_TBASE   = 12'h014;
    localparam logic [REG_AW-1:0] A_ISTAT   = 12'h018;
    localparam logic [REG_AW-1:0] A_ICLR    = 12'h01C;
    localparam logic [REG_AW-1:0] A_FA_BASE = 12'h024;
    localparam logic [REG_AW-1:0] A_VER     = 12'h034;
    localparam logic [REG_AW-1:0] A_PF_BASE = 12'h04C;

    localparam logic [DW-1:0] CTL_OFF  = 32'h0;
    localparam logic [DW-1:0] CTL_RUN  = 32'h5;
    localparam logic [DW-1:0] CTL_HOLD = 32'h7;

    typedef enum logic [1:0] {S_OFF, S_RUN, S_HOLD_REQ, S_HELD} ctl_state_e;

    // capture register index; register address is A_FA_BASE + 4*index
    typedef enum logic [1:0] {FR_PAGE, FR_WR, FR_RD, FR_BUS} freg_e;

    function automatic freg_e route_of(input logic [FT_W-1:0] t);
        freg_e r;
        unique case (t)
            3'd0:             r = FR_PAGE;
            3'd1, 3'd4, 3'd5: r = FR_RD;
            3'd2, 3'd6, 3'd7: r = FR_WR;
            default:          r = FR_BUS;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/xlt_ctrl_fsm.sv
module xlt_ctrl_fsm
    import xlt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [DW-1:0] ctl_val,
    input  logic          dp_idle,
    input  logic          flt_valid,
    output ctl_state_e    state,
    output logic          flt_accept,
    output logic          on,
    output logic          hold,
    output logic          held,
    output logic [DW-1:0] ctl_rd
);
    ctl_state_e st_q, st_d;

    logic wr_run, wr_off, wr_hold;
    assign wr_run  = ctl_wr && (ctl_val == CTL_RUN);
    assign wr_off  = ctl_wr && (ctl_val == CTL_OFF);
    assign wr_hold = ctl_wr && (ctl_val == CTL_HOLD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_OFF;
        else        st_q <= st_d;
    end

    // next state: a fault wins over any control write while translation is on
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_OFF: begin
                if (wr_run)       st_d = S_RUN;
                else if (wr_hold) st_d = S_HOLD_REQ;
            end
            S_RUN: begin
                if (flt_valid)    st_d = S_HELD;
                else if (wr_off)  st_d = S_OFF;
                else if (wr_hold) st_d = S_HOLD_REQ;
            end
            S_HOLD_REQ: begin
                if (flt_valid)    st_d = S_HELD;
                else if (wr_off)  st_d = S_OFF;
                else if (wr_run)  st_d = S_RUN;
                else if (dp_idle) st_d = S_HELD;
            end
            S_HELD: begin
                if (flt_valid)    st_d = S_HELD;
                else if (wr_off)  st_d = S_OFF;
                else if (wr_run)  st_d = S_RUN;
            end
        endcase
    end

    // outputs
    always_comb begin
        state      = st_q;
        on         = (st_q != S_OFF);
        hold       = (st_q == S_HOLD_REQ) || (st_q == S_HELD);
        held       = (st_q == S_HELD);
        flt_accept = flt_valid && (st_q != S_OFF);
        unique case (st_q)
            S_OFF:              ctl_rd = CTL_OFF;
            S_RUN:              ctl_rd = CTL_RUN;
            S_HOLD_REQ, S_HELD: ctl_rd = CTL_HOLD;
        endcase
    end
endmodule

// File: rtl/xlt_fault_log.sv
module xlt_fault_log
    import xlt_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flt_accept,
    input  logic [FT_W-1:0]               flt_type,
    input  logic [DW-1:0]                 flt_addr,
    input  logic                          clr_wr,
    input  logic [NUM_FTYPES-1:0]         clr_mask,
    output logic [NUM_FTYPES-1:0]         istat,
    output logic [NUM_FREGS-1:0][DW-1:0]  fa_regs
);
    logic [NUM_FTYPES-1:0] ist_q, set_vec, clr_vec;
    logic                  capture;
    freg_e                 dst;

    assign set_vec = flt_accept ? (NUM_FTYPES'(1) << flt_type) : '0;
    assign clr_vec = clr_wr ? clr_mask : '0;
    assign capture = flt_accept && !ist_q[flt_type];
    assign dst     = route_of(flt_type);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ist_q <= '0;
        else        ist_q <= (ist_q & ~clr_vec) | set_vec;
    end

    for (genvar g = 0; g < NUM_FREGS; g++) begin : g_fa
        logic [DW-1:0] fa_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          fa_q <= '0;
            else if (capture && dst == freg_e'(g)) fa_q <= flt_addr;
        end
        assign fa_regs[g] = fa_q;
    end

    assign istat = ist_q;
endmodule

// File: rtl/xlt_flush_gen.sv
module xlt_flush_gen
    import xlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              all_wr,
    input  logic              one_wr,
    input  logic [DW-1:0]     wdata,
    output logic              flush_all,
    output logic              flush_entry,
    output logic [PAGE_W-1:0] flush_page
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flush_all   <= 1'b0;
            flush_entry <= 1'b0;
            flush_page  <= '0;
        end else begin
            flush_all   <= all_wr && wdata[0];
            flush_entry <= one_wr && wdata[0];
            if (one_wr && wdata[0]) flush_page <= wdata[DW-1:PAGE_SHIFT];
        end
    end
endmodule

// File: rtl/xlt_ctrl_top.sv
module xlt_ctrl_top
    import xlt_pkg::*;
#(
    parameter int          NUM_WIN = 2,
    parameter logic [27:0] VER_LOW = 28'h0000100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    input  logic                  dp_idle,
    input  logic                  flt_valid,
    input  logic [FT_W-1:0]       flt_type,
    input  logic [DW-1:0]         flt_addr,
    output logic                  xlt_on,
    output logic                  xlt_hold,
    output logic                  irq,
    output logic                  flush_all,
    output logic                  flush_entry,
    output logic [PAGE_W-1:0]     flush_page,
    output logic [DW-1:0]         cfg_word,
    output logic [DW-1:0]         tbl_base,
    output logic [NUM_WIN*DW-1:0] pf_start,
    output logic [NUM_WIN*DW-1:0] pf_end
);
    localparam logic [DW-1:0] VER_WORD = {4'h3, VER_LOW};
    localparam logic [DW-1:0] PF_END_RST = '1;

    ctl_state_e                   ctl_st;
    logic                         flt_accept, held;
    logic [DW-1:0]                ctl_rd;
    logic [NUM_FTYPES-1:0]        istat;
    logic [NUM_FREGS-1:0][DW-1:0] fa_regs;
    logic [DW-1:0]                cfg_q, tbase_q;
    logic [NUM_WIN-1:0][DW-1:0]   pf_lo_q, pf_hi_q;

    xlt_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (reg_we && reg_addr == A_CTRL),
        .ctl_val    (reg_wdata),
        .dp_idle    (dp_idle),
        .flt_valid  (flt_valid),
        .state      (ctl_st),
        .flt_accept (flt_accept),
        .on         (xlt_on),
        .hold       (xlt_hold),
        .held       (held),
        .ctl_rd     (ctl_rd)
    );

    xlt_fault_log u_flog (
        .clk        (clk),
        .rst_n      (rst_n),
        .flt_accept (flt_accept),
        .flt_type   (flt_type),
        .flt_addr   (flt_addr),
        .clr_wr     (reg_we && reg_addr == A_ICLR),
        .clr_mask   (reg_wdata[NUM_FTYPES-1:0]),
        .istat      (istat),
        .fa_regs    (fa_regs)
    );

    xlt_flush_gen u_flush (
        .clk         (clk),
        .rst_n       (rst_n),
        .all_wr      (reg_we && reg_addr == A_FLALL),
        .one_wr      (reg_we && reg_addr == A_FLONE),
        .wdata       (reg_wdata),
        .flush_all   (flush_all),
        .flush_entry (flush_entry),
        .flush_page  (flush_page)
    );

    assign irq = |istat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            tbase_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == A_CFG)   cfg_q   <= reg_wdata;
            if (reg_addr == A_TBASE) tbase_q <= reg_wdata;
        end
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_pf
        localparam logic [REG_AW-1:0] A_LO = A_PF_BASE + REG_AW'(8 * w);
        localparam logic [REG_AW-1:0] A_HI = A_LO + REG_AW'(4);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pf_lo_q[w] <= '0;
                pf_hi_q[w] <= PF_END_RST;
            end else if (reg_we) begin
                if (reg_addr == A_LO) pf_lo_q[w] <= reg_wdata;
                if (reg_addr == A_HI) pf_hi_q[w] <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:                 reg_rdata = ctl_rd;
            A_CFG:                  reg_rdata = cfg_q;
            A_STAT:                 reg_rdata = {{(DW-1){1'b0}}, held};
            A_TBASE:                reg_rdata = tbase_q;
            A_ISTAT:                reg_rdata = {{(DW-NUM_FTYPES){1'b0}}, istat};
            A_VER:                  reg_rdata = VER_WORD;
            default:                reg_rdata = '0;
        endcase
        for (int f = 0; f < NUM_FREGS; f++) begin
            if (reg_addr == A_FA_BASE + REG_AW'(4 * f)) reg_rdata = fa_regs[f];
        end
        for (int w = 0; w < NUM_WIN; w++) begin
            if (reg_addr == A_PF_BASE + REG_AW'(8 * w))     reg_rdata = pf_lo_q[w];
            if (reg_addr == A_PF_BASE + REG_AW'(8 * w + 4)) reg_rdata = pf_hi_q[w];
        end
    end

    assign cfg_word = cfg_q;
    assign tbl_base = tbase_q;
    assign pf_start = pf_lo_q;
    assign pf_end   = pf_hi_q;
endmodule

// File: rtl/xlt_ctrl_chk.sv
module xlt_ctrl_chk
    import xlt_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_we,
    input logic [REG_AW-1:0]     reg_addr,
    input logic [DW-1:0]         reg_wdata,
    input logic                  dp_idle,
    input logic                  flt_valid,
    input logic                  irq,
    input logic                  flush_all,
    input logic                  flush_entry,
    input logic [PAGE_W-1:0]     flush_page,
    input ctl_state_e            ctl_st,
    input logic [NUM_FTYPES-1:0] istat,
    input logic [DW-1:0]         fa_page
);
    p_fault_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && ctl_st != S_OFF) |=> (ctl_st == S_HELD && irq));

    p_off_ignores_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && ctl_st == S_OFF && !reg_we) |=> $stable(istat));

    p_idle_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_st == S_HOLD_REQ && !dp_idle && !flt_valid) |=> (ctl_st != S_HELD));

    p_keep_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        istat[0] |=> $stable(fa_page));

    p_clear_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_ICLR && reg_wdata[0] && !flt_valid) |=> !istat[0]);

    p_flush_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |-> $past(reg_we && reg_addr == A_FLALL && reg_wdata[0]));

    p_entry_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_entry |-> (flush_page == $past(reg_wdata[DW-1:PAGE_SHIFT])));
endmodule

bind xlt_ctrl_top xlt_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .dp_idle     (dp_idle),
    .flt_valid   (flt_valid),
    .irq         (irq),
    .flush_all   (flush_all),
    .flush_entry (flush_entry),
    .flush_page  (flush_page),
    .ctl_st      (ctl_st),
    .istat       (istat),
    .fa_page     (fa_regs[0])
);

// File: tb/xlt_ctrl_top_tb.sv
module xlt_ctrl_top_tb;
    import xlt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dp_idle = 1'b1;
    logic        flt_valid = 1'b0;
    logic [2:0]  flt_type = '0;
    logic [31:0] flt_addr = '0;
    logic        xlt_on, xlt_hold, irq, flush_all, flush_entry;
    logic [19:0] flush_page;
    logic [31:0] cfg_word, tbl_base;
    logic [63:0] pf_start, pf_end;

    xlt_ctrl_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_idle(dp_idle),
        .flt_valid(flt_valid), .flt_type(flt_type), .flt_addr(flt_addr),
        .xlt_on(xlt_on), .xlt_hold(xlt_hold), .irq(irq), .flush_all(flush_all),
        .flush_entry(flush_entry), .flush_page(flush_page), .cfg_word(cfg_word),
        .tbl_base(tbl_base), .pf_start(pf_start), .pf_end(pf_end)
    );

    always #5 clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    int          m_st = 0;           // 0 off, 1 run, 2 hold requested, 3 held
    logic [7:0]  m_ist = '0;
    logic [31:0] m_fa [4];

    function automatic int route(input int t);
        if (t == 0) return 0;
        if (t == 1 || t == 4 || t == 5) return 2;
        if (t == 3) return 3;
        return 1;
    endfunction

    function automatic logic [31:0] ctl_exp(input int st);
        if (st == 0) return 32'h0;
        if (st == 1) return 32'h5;
        return 32'h7;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // one clock edge; the model steps with the inputs driven for this edge
    task automatic cycle();
        int         nst = m_st;
        logic [7:0] nist = m_ist;
        if (reg_we && reg_addr == 12'h01C) nist = nist & ~reg_wdata[7:0];
        if (flt_valid && m_st != 0) begin
            if (!m_ist[flt_type]) m_fa[route(int'(flt_type))] = flt_addr;
            nist = nist | (8'd1 << flt_type);
            nst = 3;
        end else if (reg_we && reg_addr == 12'h000 && reg_wdata == 32'h5) nst = 1;
        else if (reg_we && reg_addr == 12'h000 && reg_wdata == 32'h0) nst = 0;
        else if (reg_we && reg_addr == 12'h000 && reg_wdata == 32'h7 && m_st < 2) nst = 2;
        else if (m_st == 2 && dp_idle) nst = 3;
        @(posedge clk);
        #1;
        m_st  = nst;
        m_ist = nist;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cycle();
        reg_we = 1'b0;
    endtask

    task automatic fault(input logic [2:0] t, input logic [31:0] a);
        flt_valid = 1'b1; flt_type = t; flt_addr = a;
        cycle();
        flt_valid = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk_model(input string tag);
        logic [31:0] d;
        rd(12'h000, d); chk({tag, " R2 control"}, d, ctl_exp(m_st));
        rd(12'h008, d); chk({tag, " R3 status"}, d, {31'd0, m_st == 3});
        rd(12'h018, d); chk({tag, " R7 istat"}, d, {24'd0, m_ist});
        chk({tag, " R7 irq"}, {31'd0, irq}, {31'd0, |m_ist});
        for (int i = 0; i < 4; i++) begin
            rd(12'(12'h024 + 4 * i), d);
            chk({tag, " R5 fault addr"}, d, m_fa[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4; i++) m_fa[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(12'h000, d); chk("R1 control", d, 32'h0);
        rd(12'h008, d); chk("R1 status", d, 32'h0);
        rd(12'h018, d); chk("R1 istat", d, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(12'h04C, d); chk("R1 pf0 start", d, 32'h0);
        rd(12'h058, d); chk("R1 pf1 end", d, 32'hFFFF_FFFF);
        rd(12'h034, d); chk("R12 version major", {28'd0, d[31:28]}, 32'd3);
        rd(12'h040, d); chk("R12 unmapped", d, 32'h0);

        // R2 control encodings
        wr(12'h000, 32'h3);
        rd(12'h000, d); chk("R2 bad value ignored", d, 32'h0);
        wr(12'h000, 32'h5);
        rd(12'h000, d); chk("R2 run", d, 32'h5);
        chk("R2 on/hold", {30'd0, xlt_on, xlt_hold}, 32'b10);

        // R3 hold handshake
        dp_idle = 1'b0;
        wr(12'h000, 32'h7);
        rd(12'h000, d); chk("R2 hold readback", d, 32'h7);
        rd(12'h008, d); chk("R3 not held before idle", d, 32'h0);
        chk("R2 hold out", {31'd0, xlt_hold}, 32'd1);
        cycle(); cycle();
        rd(12'h008, d); chk("R3 still waiting", d, 32'h0);
        dp_idle = 1'b1;
        cycle();
        rd(12'h008, d); chk("R3 held after idle", d, 32'h1);
        wr(12'h000, 32'h5);
        rd(12'h008, d); chk("R3 resume", d, 32'h0);

        // R4 R5 R6 fault capture
        fault(3'd5, 32'hA5A5_1000);
        chk("R4 irq", {31'd0, irq}, 32'd1);
        rd(12'h018, d); chk("R4 istat bit5", d, 32'h20);
        rd(12'h008, d); chk("R4 self held", d, 32'h1);
        rd(12'h02C, d); chk("R5 read-side addr", d, 32'hA5A5_1000);
        fault(3'd5, 32'h1111_2000);
        rd(12'h02C, d); chk("R6 no overwrite", d, 32'hA5A5_1000);

        // R7 clear
        wr(12'h01C, 32'h0);
        rd(12'h018, d); chk("R7 zero mask keeps", d, 32'h20);
        wr(12'h01C, 32'h20);
        rd(12'h018, d); chk("R7 cleared", d, 32'h0);
        chk("R7 irq low", {31'd0, irq}, 32'd0);
        wr(12'h000, 32'h5);

        // R4 fault beats control write in the same cycle
        reg_we = 1'b1; reg_addr = 12'h000; reg_wdata = 32'h0;
        flt_valid = 1'b1; flt_type = 3'd3; flt_addr = 32'hDEAD_0000;
        cycle();
        reg_we = 1'b0; flt_valid = 1'b0;
        rd(12'h000, d); chk("R4 fault wins over write", d, 32'h7);
        rd(12'h030, d); chk("R5 bus error addr", d, 32'hDEAD_0000);
        wr(12'h01C, 32'hFF);

        // R4 fault ignored when off
        wr(12'h000, 32'h0);
        fault(3'd0, 32'h5555_0000);
        rd(12'h018, d); chk("R4 off ignores fault", d, 32'h0);
        rd(12'h024, d); chk("R4 off no capture", d, 32'h0);

        // R8 flush all
        wr(12'h00C, 32'h1);
        chk("R8 pulse", {31'd0, flush_all}, 32'd1);
        cycle();
        chk("R8 one cycle", {31'd0, flush_all}, 32'd0);
        wr(12'h00C, 32'h0);
        chk("R8 bit0 clear no pulse", {31'd0, flush_all}, 32'd0);

        // R9 entry flush
        wr(12'h010, 32'h1234_5001);
        chk("R9 pulse", {31'd0, flush_entry}, 32'd1);
        chk("R9 page", {12'd0, flush_page}, 32'h12345);
        wr(12'h010, 32'h6789_A000);
        chk("R9 bit0 clear no pulse", {31'd0, flush_entry}, 32'd0);

        // R10 R11 R12
        wr(12'h004, 32'h0000_1001);
        rd(12'h004, d); chk("R10 cfg read", d, 32'h0000_1001);
        chk("R10 cfg out", cfg_word, 32'h0000_1001);
        wr(12'h014, 32'h8000_4000);
        chk("R10 base out", tbl_base, 32'h8000_4000);
        wr(12'h054, 32'h0010_0000);
        wr(12'h058, 32'h001F_FFFF);
        chk("R11 pf1 start", pf_start[63:32], 32'h0010_0000);
        chk("R11 pf1 end", pf_end[63:32], 32'h001F_FFFF);
        chk("R11 pf0 end untouched", pf_end[31:0], 32'hFFFF_FFFF);
        wr(12'h04C, 32'h0000_2000);
        rd(12'h04C, d); chk("R11 pf0 start read", d, 32'h0000_2000);
        wr(12'h034, 32'h0);
        rd(12'h034, d); chk("R12 version read-only", {28'd0, d[31:28]}, 32'd3);

        // random mix
        wr(12'h000, 32'h5);
        for (int it = 0; it < 400; it++) begin
            int r = $urandom_range(0, 9);
            int v = $urandom_range(0, 5);
            dp_idle = 1'($urandom_range(0, 1));
            flt_valid = (r < 4) || (r == 9);
            flt_type = 3'($urandom_range(0, 7));
            flt_addr = $urandom;
            reg_we = (r >= 4);
            if (r < 7 || r == 9) begin
                reg_addr = 12'h01C; reg_wdata = {24'd0, 8'($urandom)};
            end else begin
                reg_addr = 12'h000;
                reg_wdata = (v < 3) ? 32'h5 : (v == 3) ? 32'h7 : (v == 4) ? 32'h0 : 32'h3;
            end
            cycle();
            reg_we = 1'b0; flt_valid = 1'b0;
            chk_model("rand R4 R6");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule